// File: doc/BRIEF.md
# Programmable Memory-to-Memory Copy Channel

The block is one copy channel. Software sets it up through three word-wide registers: a source address, a destination address and a control word. It then moves a counted run of 16-bit or 32-bit units from the source to the destination. Each unit passes over a memory master port as one read handshake followed by one write handshake. The control word sets the unit size, the address stepping for each side (up, down or held), how the copy starts, whether the channel stays armed after a run, and whether a one-cycle interrupt pulse marks the end of a run.

A run starts in one of two ways. It can start at once when software arms the channel, or it can wait until an external event input presents the same start code that the control word holds. With the repeat option set, the channel stays armed after a run and answers later events. Each new run reloads the unit count. The working addresses carry on from where the last run stopped, except when the destination is set to reload its start address. The parameter `VARIANT` picks between two layouts of the control word. The layouts differ in the width and position of the start-code field and in the width of the count field.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset all three registers read zero, `rd_valid`, `wr_valid` and `irq` are low, and no unit moves.
- R2: With `reg_sel` 0 selecting the source address, 1 the destination address and 2 the control word, a write stores the value and `reg_rdata` returns it.
- R3: The working addresses are loaded from the programmed source and destination registers only when a write to the control word changes bit 31 (arm) from 0 to 1. Writing the control word again while bit 31 is already set starts nothing.
- R4: Control bits 18:17 set the destination stepping: 00 steps up, 01 steps down, 10 holds the address, and 11 steps up and also reloads the working destination from the programmed destination at the start of every run.
- R5: Control bits 20:19 set the source stepping: 00 steps up, 01 steps down, 10 holds the address, and 11 steps up.
- R6: Control bit 26 set selects 16-bit units with a 2-byte address step, carried in `wr_data[15:0]`. When it is clear, units are 32 bits with a 4-byte step.
- R7: The start code is bits 29:27 when `VARIANT` is 0 and bits 29:28 when `VARIANT` is 1. A start code of zero starts the run on the same write that arms the channel.
- R8: A non-zero start code starts a run only when `trig_valid` is high with `trig_mode` equal to that code while the channel is armed and idle. Events carrying any other code have no effect.
- R9: The unit count is the low 21 bits of the control word when `VARIANT` is 0. When `VARIANT` is 1 it is the low 14 bits, or the low 16 bits when `CHAN_IDX` is 3. A count of zero moves 2 to the power of the count width units.
- R10: At the end of a run, bit 31 of the control word is cleared when bit 25 (repeat) is 0. When bit 25 is 1, bit 31 stays set and each later matching event runs the full count again.
- R11: When control bit 30 is set, `irq` is high for exactly the one cycle after the last write handshake of a run. When bit 30 is clear, `irq` stays low.
- R12: Each unit makes one read handshake and then one write handshake. Address, size and data stay unchanged while the other side holds ready low. `rd_valid` and `wr_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| trig_valid | input | 1 | Start event strobe |
| trig_mode | input | 3 | Start code carried by the event |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted, data present on rd_data |
| rd_addr | output | ADDR_W | Read byte address |
| rd_half | output | 1 | Read is a 16-bit unit |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_half | output | 1 | Write is a 16-bit unit |
| wr_data | output | 32 | Write data |
| irq | output | 1 | Completion pulse |

## Verification
The bench runs every combination of unit size, source stepping and destination stepping, and checks the address and data of every write against a model. A wrong sign or a wrong step size shows up at the second unit, and a reserved source code that held the address would repeat the first datum. Armed event runs check the reload of the 11 destination code across repeats, and check that a design which restarts on any write with bit 31 set, or reloads addresses without an arming edge, moves extra or misplaced units. A zero count on the 14-bit variant and a count with bit 14 set on the 21-bit variant catch a wrong count mask or a missing "zero means maximum" rule. The mismatched event codes catch a design that decodes the start code from the wrong bits.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        STEP_INC = 2'd0,
        STEP_DEC = 2'd1,
        STEP_FIX = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int ARM_BIT  = 31;
    localparam int IRQ_BIT  = 30;
    localparam int HALF_BIT = 26;
    localparam int REP_BIT  = 25;

    // width of the unit-count field for a given layout and channel slot
    function automatic int count_width(input int variant, input int chan);
        if (variant == 0)   return 21;
        else if (chan == 3) return 16;
        else                return 14;
    endfunction

endpackage

// File: rtl/dma_ctrl_fields.sv
module dma_ctrl_fields
    import dma_chan_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int CNT_W   = 21
) (
    input  logic [31:0]    word,
    output logic [2:0]     start_mode,
    output logic [CNT_W:0] units,
    output step_e          src_step,
    output step_e          dst_step,
    output logic           dst_reload,
    output logic           half,
    output logic           repeat_en,
    output logic           irq_en
);
    logic unused_word;
    assign unused_word = ^word;

    generate
        if (VARIANT == 0) begin : g_wide_code
            assign start_mode = word[29:27];
        end else begin : g_narrow_code
            assign start_mode = {1'b0, word[29:28]};
        end
    endgenerate

    assign units = (word[CNT_W-1:0] == '0) ? {1'b1, {CNT_W{1'b0}}}
                                           : {1'b0, word[CNT_W-1:0]};

    always_comb begin
        unique case (word[20:19])
            2'b01:   src_step = STEP_DEC;
            2'b10:   src_step = STEP_FIX;
            default: src_step = STEP_INC;
        endcase
        unique case (word[18:17])
            2'b01:   dst_step = STEP_DEC;
            2'b10:   dst_step = STEP_FIX;
            default: dst_step = STEP_INC;
        endcase
    end

    assign dst_reload = (word[18:17] == 2'b11);
    assign half       = word[HALF_BIT];
    assign repeat_en  = word[REP_BIT];
    assign irq_en     = word[IRQ_BIT];
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  step_e             mode,
    input  logic              half,
    output logic [ADDR_W-1:0] next
);
    logic [ADDR_W-1:0] delta;
    assign delta = half ? ADDR_W'(2) : ADDR_W'(4);

    always_comb begin
        unique case (mode)
            STEP_DEC: next = addr - delta;
            STEP_FIX: next = addr;
            default:  next = addr + delta;
        endcase
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int VARIANT  = 0,
    parameter int CHAN_IDX = 0,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              trig_valid,
    input  logic [2:0]        trig_mode,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_half,
    input  logic [31:0]       rd_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_half,
    output logic [31:0]       wr_data,
    output logic              irq
);
    localparam int CNT_W = count_width(VARIANT, CHAN_IDX);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [31:0]       ctrl;
        logic [ADDR_W-1:0] cur_src;
        logic [ADDR_W-1:0] cur_dst;
        logic [CNT_W:0]    rem;
        logic [31:0]       data;
        step_e             sstep;
        step_e             dstep;
        logic              reload;
        logic              half;
        logic              irq;
        state_e            st;
    } regs_t;

    regs_t r_q, r_d;

    // arming edge: control write that raises bit 31
    logic arm_edge;
    assign arm_edge = reg_we && (reg_sel == SEL_CTRL) && reg_wdata[ARM_BIT]
                      && !r_q.ctrl[ARM_BIT];

    // on the arming write the new word is decoded, otherwise the stored one
    logic [31:0] ctrl_eff;
    assign ctrl_eff = arm_edge ? reg_wdata : r_q.ctrl;

    logic [2:0]     f_mode;
    logic [CNT_W:0] f_units;
    step_e          f_sstep, f_dstep;
    logic           f_reload, f_half, f_rep, f_irq;

    dma_ctrl_fields #(.VARIANT(VARIANT), .CNT_W(CNT_W)) u_fields (
        .word       (ctrl_eff),
        .start_mode (f_mode),
        .units      (f_units),
        .src_step   (f_sstep),
        .dst_step   (f_dstep),
        .dst_reload (f_reload),
        .half       (f_half),
        .repeat_en  (f_rep),
        .irq_en     (f_irq)
    );

    logic [ADDR_W-1:0] src_nx, dst_nx;

    dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
        .addr (r_q.cur_src),
        .mode (r_q.sstep),
        .half (r_q.half),
        .next (src_nx)
    );

    dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .addr (r_q.cur_dst),
        .mode (r_q.dstep),
        .half (r_q.half),
        .next (dst_nx)
    );

    logic ev_hit;
    assign ev_hit = trig_valid && (trig_mode == f_mode) && (f_mode != 3'd0)
                    && r_q.ctrl[ARM_BIT];

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;

        if (reg_we) begin
            unique case (reg_sel)
                SEL_SRC:  r_d.src  = ADDR_W'(reg_wdata);
                SEL_DST:  r_d.dst  = ADDR_W'(reg_wdata);
                SEL_CTRL: r_d.ctrl = reg_wdata;
                default:  ;
            endcase
        end

        unique case (r_q.st)
            ST_READ: begin
                if (rd_ready) begin
                    r_d.data = rd_data;
                    r_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (wr_ready) begin
                    r_d.cur_src = src_nx;
                    r_d.cur_dst = dst_nx;
                    r_d.rem     = r_q.rem - 1'b1;
                    if (r_q.rem == (CNT_W+1)'(1)) begin
                        r_d.st  = ST_IDLE;
                        r_d.irq = f_irq;
                        if (!f_rep) r_d.ctrl[ARM_BIT] = 1'b0;
                    end else begin
                        r_d.st = ST_READ;
                    end
                end
            end
            default: ;
        endcase

        if (arm_edge) begin
            r_d.cur_src = r_q.src;
            r_d.cur_dst = r_q.dst;
            r_d.sstep   = f_sstep;
            r_d.dstep   = f_dstep;
            r_d.reload  = f_reload;
        end

        if (r_q.st == ST_IDLE && ((arm_edge && f_mode == 3'd0) || (!arm_edge && ev_hit))) begin
            r_d.rem  = f_units;
            r_d.half = f_half;
            r_d.st   = ST_READ;
            if (arm_edge ? f_reload : r_q.reload) r_d.cur_dst = r_q.dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.sstep <= STEP_INC;
            r_q.dstep <= STEP_INC;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_SRC:  reg_rdata = 32'(r_q.src);
            SEL_DST:  reg_rdata = 32'(r_q.dst);
            SEL_CTRL: reg_rdata = r_q.ctrl;
            default:  reg_rdata = '0;
        endcase
    end

    assign rd_valid = (r_q.st == ST_READ);
    assign rd_addr  = r_q.cur_src;
    assign rd_half  = r_q.half;
    assign wr_valid = (r_q.st == ST_WRITE);
    assign wr_addr  = r_q.cur_dst;
    assign wr_half  = r_q.half;
    assign wr_data  = r_q.data;
    assign irq      = r_q.irq;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_half,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              irq
);
    p_bus_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_half)));

    p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(wr_valid && wr_ready));

    p_read_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_valid);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_addr  (rd_addr),
    .rd_half  (rd_half),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq      (irq)
);

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_we_a = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, reg_rdata_a;
    logic        trig_valid = 1'b0;
    logic [2:0]  trig_mode = 3'd0;
    logic        rd_valid, rd_half, wr_valid, wr_half, irq;
    logic        rd_ready = 1'b1, wr_ready = 1'b1;
    logic [31:0] rd_addr, wr_addr, rd_data, wr_data;
    logic        a_rd_valid, a_rd_half, a_wr_valid, a_wr_half, a_irq;
    logic [31:0] a_rd_addr, a_wr_addr, a_wr_data;

    int checks = 0, failures = 0;
    int run_units = 0, irq_seen = 0, a_units = 0, a_irq_seen = 0;
    logic [31:0] exp_src, exp_dst;
    int sstep = 4, dstep = 4;
    logic exp_half = 1'b0;
    logic stall_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    dma_chan_engine #(.VARIANT(1), .CHAN_IDX(0), .ADDR_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig_valid(trig_valid), .trig_mode(trig_mode),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_half(rd_half), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_half(wr_half), .wr_data(wr_data), .irq(irq)
    );

    dma_chan_engine #(.VARIANT(0), .CHAN_IDX(0), .ADDR_W(32)) dut_a (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we_a), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata_a),
        .trig_valid(trig_valid), .trig_mode(trig_mode),
        .rd_valid(a_rd_valid), .rd_ready(1'b1), .rd_addr(a_rd_addr),
        .rd_half(a_rd_half), .rd_data(32'h0),
        .wr_valid(a_wr_valid), .wr_ready(1'b1), .wr_addr(a_wr_addr),
        .wr_half(a_wr_half), .wr_data(a_wr_data), .irq(a_irq)
    );

    function automatic logic [15:0] pat16(input logic [31:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[7:0], a[15:8]};
    endfunction

    assign rd_data = rd_half ? {16'h0, pat16(rd_addr)}
                             : {pat16(rd_addr + 32'd2), pat16(rd_addr)};

    always @(posedge clk) begin
        #1;
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd_ready <= !stall_on || lfsr[0];
        wr_ready <= !stall_on || lfsr[3];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write monitor: address and data of every unit against the model (R4 R5 R6 R12)
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            logic [31:0] ed;
            ed = exp_half ? {16'h0, pat16(exp_src)} : {pat16(exp_src + 32'd2), pat16(exp_src)};
            check(wr_addr == exp_dst && wr_half == exp_half, "R4 write address", wr_addr, exp_dst);
            check(exp_half ? (wr_data[15:0] == ed[15:0]) : (wr_data == ed), "R5 R6 write data", wr_data, ed);
            exp_src = exp_src + 32'(sstep);
            exp_dst = exp_dst + 32'(dstep);
            run_units++;
        end
        if (rst_n && irq) irq_seen++;
        if (rst_n && a_wr_valid) a_units++;
        if (rst_n && a_irq) a_irq_seen++;
    end

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d, input bit to_a);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d;
        if (to_a) reg_we_a = 1'b1; else reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_we_a = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_trig(input logic [2:0] m);
        @(negedge clk);
        trig_valid = 1'b1; trig_mode = m;
        @(negedge clk);
        trig_valid = 1'b0; trig_mode = 3'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_units(input int n, input int limit);
        for (int i = 0; i < limit && run_units < n; i++) @(negedge clk);
    endtask

    localparam logic [31:0] ARM = 32'h8000_0000;
    localparam logic [31:0] IEN = 32'h4000_0000;
    localparam logic [31:0] REP = 32'h0200_0000;
    localparam logic [31:0] HLF = 32'h0400_0000;

    int cycles = 0;
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 3; s++) begin
            rd_reg(2'(s), v);
            check(v == 32'h0, "R1 register reset", v, 32'h0);
        end
        check(!rd_valid && !wr_valid && !irq, "R1 bus idle", {29'h0, rd_valid, wr_valid, irq}, 32'h0);

        // R2 readback
        wr_reg(2'd0, 32'h1234_5678, 1'b0);
        wr_reg(2'd1, 32'h9ABC_DEF0, 1'b0);
        wr_reg(2'd2, 32'h0000_0005, 1'b0);
        rd_reg(2'd0, v); check(v == 32'h1234_5678, "R2 source readback", v, 32'h1234_5678);
        rd_reg(2'd1, v); check(v == 32'h9ABC_DEF0, "R2 dest readback", v, 32'h9ABC_DEF0);
        rd_reg(2'd2, v); check(v == 32'h0000_0005, "R2 control readback", v, 32'h5);
        idle(5);
        check(run_units == 0, "R3 no run without arm edge", run_units, 0);

        // sweep of size and both stepping codes, immediate start (R4 R5 R6 R7 R9 R10 R11)
        for (int sz = 0; sz < 2; sz++) begin
            for (int sm = 0; sm < 4; sm++) begin
                for (int dm = 0; dm < 4; dm++) begin
                    int unit;
                    unit     = sz ? 2 : 4;
                    sstep    = (sm == 1) ? -unit : (sm == 2) ? 0 : unit;
                    dstep    = (dm == 1) ? -unit : (dm == 2) ? 0 : unit;
                    exp_half = sz[0];
                    stall_on = sz[0];
                    exp_src  = 32'h0000_1000;
                    exp_dst  = 32'h0000_8000;
                    run_units = 0; irq_seen = 0;
                    wr_reg(2'd0, 32'h0000_1000, 1'b0);
                    wr_reg(2'd1, 32'h0000_8000, 1'b0);
                    wr_reg(2'd2, ARM | IEN | (sz ? HLF : 32'h0) | (32'(sm) << 19) | (32'(dm) << 17) | 32'd3, 1'b0);
                    wait_units(3, 200);
                    idle(4);
                    check(run_units == 3, "R9 R7 unit count", run_units, 3);
                    check(irq_seen == 1, "R11 one irq per run", irq_seen, 1);
                    rd_reg(2'd2, v);
                    check(v[31] == 1'b0, "R10 arm cleared without repeat", v, 32'h0);
                end
            end
        end
        stall_on = 1'b0;

        // R3: re-writing an armed control word does not restart; arm edge copies new source
        exp_half = 1'b0; sstep = 4; dstep = 4;
        exp_src = 32'h3000; exp_dst = 32'hA000;
        run_units = 0; irq_seen = 0;
        wr_reg(2'd0, 32'h3000, 1'b0);
        wr_reg(2'd1, 32'hA000, 1'b0);
        wr_reg(2'd2, ARM | REP | 32'd2, 1'b0);
        wait_units(2, 100); idle(4);
        check(run_units == 2, "R10 repeat run count", run_units, 2);
        check(irq_seen == 0, "R11 no irq when disabled", irq_seen, 0);
        rd_reg(2'd2, v);
        check(v[31] == 1'b1, "R10 arm kept with repeat", v, ARM | REP | 32'd2);
        run_units = 0;
        wr_reg(2'd0, 32'h5000, 1'b0);
        wr_reg(2'd2, ARM | REP | 32'd2, 1'b0);
        idle(20);
        check(run_units == 0, "R3 no restart while armed", run_units, 0);
        wr_reg(2'd2, 32'h0, 1'b0);
        exp_src = 32'h5000; exp_dst = 32'hA000;
        wr_reg(2'd2, ARM | 32'd2, 1'b0);
        wait_units(2, 100); idle(4);
        check(run_units == 2, "R3 rearm runs from programmed source", run_units, 2);

        // R8 event start with 2-bit code at 29:28, repeat, destination reload (R4)
        wr_reg(2'd0, 32'h2000, 1'b0);
        wr_reg(2'd1, 32'h9000, 1'b0);
        run_units = 0; irq_seen = 0;
        wr_reg(2'd2, ARM | IEN | REP | (32'd2 << 28) | (32'd3 << 17) | 32'd2, 1'b0);
        idle(10);
        check(run_units == 0, "R8 no start without event", run_units, 0);
        pulse_trig(3'd1);
        idle(10);
        check(run_units == 0, "R8 wrong code ignored", run_units, 0);
        exp_src = 32'h2000; exp_dst = 32'h9000; sstep = 4; dstep = 4;
        pulse_trig(3'd2);
        wait_units(2, 100); idle(4);
        check(run_units == 2, "R8 matching event runs", run_units, 2);
        check(irq_seen == 1, "R11 irq after event run", irq_seen, 1);
        rd_reg(2'd2, v);
        check(v[31] == 1'b1, "R10 armed after repeat run", v, 32'h8000_0000);
        exp_dst = 32'h9000;  // source continues at 0x2008, destination reloads
        run_units = 0;
        pulse_trig(3'd2);
        wait_units(2, 100); idle(4);
        check(run_units == 2, "R10 second repeat run full count", run_units, 2);
        check(exp_src == 32'h2010, "R4 source continued across repeat", exp_src, 32'h2010);
        wr_reg(2'd2, 32'h0, 1'b0);

        // R9 zero count on the 14-bit layout: 16384 units
        exp_half = 1'b1; sstep = 0; dstep = 0;
        exp_src = 32'h4000; exp_dst = 32'hB000;
        run_units = 0;
        wr_reg(2'd0, 32'h4000, 1'b0);
        wr_reg(2'd1, 32'hB000, 1'b0);
        wr_reg(2'd2, ARM | HLF | (32'd2 << 19) | (32'd2 << 17), 1'b0);
        wait_units(16384, 40000); idle(6);
        check(run_units == 16384, "R9 zero count means maximum", run_units, 16384);

        // R7 R9 on the 21-bit layout: code 5 at 29:27, count 0x4003
        a_units = 0; a_irq_seen = 0;
        wr_reg(2'd2, ARM | IEN | (32'd5 << 27) | 32'h4003, 1'b1);
        pulse_trig(3'd2);
        idle(10);
        check(a_units == 0, "R7 code read from bits 29:27", a_units, 0);
        pulse_trig(3'd5);
        for (int i = 0; i < 40000 && a_units < 16387; i++) @(negedge clk);
        idle(6);
        check(a_units == 16387, "R9 21-bit count field", a_units, 16387);
        check(a_irq_seen == 1, "R11 irq on 21-bit layout", a_irq_seen, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule